// File: doc/BRIEF.md
# Read/Write Start Arbiter with Write Forwarding

This block sits in front of a burst memory that has separate read and write data paths but a single multiplexed address bus. On every rising clock edge it looks at the read select, the write select and the shared address, and starts at most one burst. When both selects are high, the winner depends on what the previous edge started. From an idle state a read wins. After a read, the write wins. After a write, the read wins. Holding both selects high therefore gives read, write, read, write. A burst of either kind also occupies two edges, so a request of the same kind as the burst that has just started is refused. A refused or losing request is dropped, not queued. The requester must raise it again.

The block also makes a read observe a write that has not yet been committed to the array. If a read starts on the edge right after a write to the same address, the block merges byte by byte. Bytes whose write mask bit is set come from the write port's pending data register. The other bytes come from the array read data. The merged word is registered and presented with a valid pulse.

Top module: `rw_start_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, rd_start, wr_start, rd_valid and rd_fwd are 0. The arbiter's history is "nothing started".
- R2: On any edge at most one of rd_start and wr_start becomes 1.
- R3: If both selects are high and the previous edge started nothing, a read starts.
- R4: If both selects are high and the previous edge started a read, a write starts.
- R5: If both selects are high and the previous edge started a write, a read starts.
- R6: Holding both selects high from idle starts read, write, read, write on successive edges.
- R7: A request of the same kind as the burst started on the previous edge starts nothing and is not kept. With no select on the following edge, nothing starts.
- R8: rd_addr or wr_addr takes the value of addr sampled on the edge where that kind of burst started. It holds that value until the next start of the same kind.
- R9: A read started on the edge right after a write to the same address returns, for each byte i with wbuf_mask[i]=1, bits [8i+7:8i] of wbuf_data. Each other byte comes from arr_rdata. rd_fwd is 1 with that word.
- R10: A read that does not meet the R9 condition returns arr_rdata unchanged, with rd_fwd=0. This covers a different address, and also a write that is not on the immediately preceding edge.
- R11: arr_rdata, wbuf_data and wbuf_mask are sampled in the cycle in which rd_start is 1. rd_valid is 1 exactly in the cycle after each rd_start, and rd_data carries the resulting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all decisions on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 1 | Read request for this edge |
| wr_sel | input | 1 | Write request for this edge |
| addr | input | ADDR_W | Shared address, taken by the winning request |
| wbuf_data | input | NUM_BYTES*BYTE_W | Pending write data register contents |
| wbuf_mask | input | NUM_BYTES | Byte mask of the pending write, 1 = byte written |
| arr_rdata | input | NUM_BYTES*BYTE_W | Array data for the read in progress |
| rd_start | output | 1 | One-cycle pulse: a read burst started |
| rd_addr | output | ADDR_W | Address of the most recent read start |
| wr_start | output | 1 | One-cycle pulse: a write burst started |
| wr_addr | output | ADDR_W | Address of the most recent write start |
| rd_valid | output | 1 | rd_data holds a read word |
| rd_data | output | NUM_BYTES*BYTE_W | Read word after forwarding merge |
| rd_fwd | output | 1 | The word in rd_data used forwarded bytes |

## Verification
On every cycle the assertions check the history-based priority, the refusal of back-to-back starts of the same kind, and the capture of the start addresses. They also check that a forward hit only accompanies a read to the address of the write just started, and the byte sources of each registered read word. Only the bench scenarios can show the longer patterns. These are the read-first alternation over many edges, a dropped request staying dropped, and a write separated from a read by an idle edge not being forwarded. They also include the full merged word compared against an independently computed value under random masks and addresses.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

    // Kind of burst started on an edge; also the arbiter's one-edge history.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } start_t;

    // A burst spans two edges, so the kind that just started is not eligible.
    // Read is checked first: with both eligible the history must be idle.
    function automatic op_e pick_op(input logic rq, input logic wq, input op_e last);
        logic rd_ok;
        logic wr_ok;
        rd_ok = rq && (last != OP_RD);
        wr_ok = wq && (last != OP_WR);
        if (rd_ok) return OP_RD;
        if (wr_ok) return OP_WR;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/rwa_grant.sv
module rwa_grant
    import rwa_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    output start_t            start,
    output logic              rd_win,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);

    op_e last_op;
    op_e nxt_op;

    always_comb nxt_op = pick_op(rd_req, wr_req, last_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_op <= OP_NONE;
            rd_addr <= '0;
            wr_addr <= '0;
        end else begin
            last_op <= nxt_op;
            if (nxt_op == OP_RD) rd_addr <= addr;
            if (nxt_op == OP_WR) wr_addr <= addr;
        end
    end

    assign start.rd = (last_op == OP_RD);
    assign start.wr = (last_op == OP_WR);
    assign rd_win   = (nxt_op == OP_RD);

    // R3 / R5: both requested and no read just started -> read next
    a_r3_read_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req && !start.rd) |=> start.rd);
    // R4: both requested right after a read -> write next
    a_r4_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req && start.rd) |=> start.wr);
    // R7: no two reads or two writes on consecutive edges
    a_r7_no_rd_repeat: assert property (@(posedge clk) disable iff (rst)
        start.rd |=> !start.rd);
    a_r7_no_wr_repeat: assert property (@(posedge clk) disable iff (rst)
        start.wr |=> !start.wr);
    // R8: start addresses come from the shared bus at the winning edge
    a_r8_rd_addr: assert property (@(posedge clk) disable iff (rst)
        rd_win |=> (rd_addr == $past(addr)));
    a_r8_wr_addr: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_win && !start.wr) |=> (wr_addr == $past(addr)));

endmodule

// File: rtl/rwa_hit.sv
module rwa_hit #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_win,
    input  logic              wr_started,
    input  logic              rd_started,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              fwd_pend
);

    logic same_addr;

    assign same_addr = (wr_addr == addr);

    // Flag for the read now starting: the write began on the edge just before.
    always_ff @(posedge clk) begin
        if (rst) fwd_pend <= 1'b0;
        else     fwd_pend <= rd_win && wr_started && same_addr;
    end

    // R9: a forward hit only ever belongs to a read just started
    a_r9_hit_with_read: assert property (@(posedge clk) disable iff (rst)
        fwd_pend |-> rd_started);
    // R9: and that read targets the address of the write just started
    a_r9_hit_same_addr: assert property (@(posedge clk) disable iff (rst)
        fwd_pend |-> (rd_addr == wr_addr));
    // R10: no hit unless a write started on the previous edge
    a_r10_hit_needs_write: assert property (@(posedge clk) disable iff (rst)
        !wr_started |=> !fwd_pend);

endmodule

// File: rtl/rwa_merge.sv
module rwa_merge #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_started,
    input  logic                        fwd_pend,
    input  logic [NUM_BYTES*BYTE_W-1:0] arr_rdata,
    input  logic [NUM_BYTES*BYTE_W-1:0] wbuf_data,
    input  logic [NUM_BYTES-1:0]        wbuf_mask,
    output logic                        rd_valid,
    output logic [NUM_BYTES*BYTE_W-1:0] rd_data,
    output logic                        rd_fwd
);

    localparam int DATA_W = NUM_BYTES * BYTE_W;

    logic [DATA_W-1:0] merged;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        logic take_wr;
        assign take_wr = fwd_pend && wbuf_mask[g];
        assign merged[g*BYTE_W +: BYTE_W] = take_wr ? wbuf_data[g*BYTE_W +: BYTE_W]
                                                    : arr_rdata[g*BYTE_W +: BYTE_W];

        // R9: a masked byte of a forwarded read comes from the write register
        a_r9_byte_from_write: assert property (@(posedge clk) disable iff (rst)
            (rd_started && fwd_pend && wbuf_mask[g]) |=>
                (rd_data[g*BYTE_W +: BYTE_W] == $past(wbuf_data[g*BYTE_W +: BYTE_W])));
        // R9: an unmasked byte still comes from the array
        a_r9_byte_from_array: assert property (@(posedge clk) disable iff (rst)
            (rd_started && !(fwd_pend && wbuf_mask[g])) |=>
                (rd_data[g*BYTE_W +: BYTE_W] == $past(arr_rdata[g*BYTE_W +: BYTE_W])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_fwd   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_started;
            rd_fwd   <= rd_started && fwd_pend;
            if (rd_started) rd_data <= merged;
        end
    end

    // R11: one valid word per read start, one cycle later
    a_r11_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        rd_started |=> rd_valid);
    a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_started |=> !rd_valid);
    // R10: an unforwarded read leaves the array word untouched
    a_r10_plain_word: assert property (@(posedge clk) disable iff (rst)
        (rd_started && !fwd_pend) |=> (!rd_fwd && rd_data == $past(arr_rdata)));

endmodule

// File: rtl/rw_start_arbiter.sv
module rw_start_arbiter
    import rwa_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_sel,
    input  logic                        wr_sel,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES*BYTE_W-1:0] wbuf_data,
    input  logic [NUM_BYTES-1:0]        wbuf_mask,
    input  logic [NUM_BYTES*BYTE_W-1:0] arr_rdata,
    output logic                        rd_start,
    output logic [ADDR_W-1:0]           rd_addr,
    output logic                        wr_start,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic                        rd_valid,
    output logic [NUM_BYTES*BYTE_W-1:0] rd_data,
    output logic                        rd_fwd
);

    start_t            start;
    logic              rd_win;
    logic              fwd_pend;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [ADDR_W-1:0] wr_addr_q;

    rwa_grant #(.ADDR_W(ADDR_W)) u_grant (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (rd_sel),
        .wr_req  (wr_sel),
        .addr    (addr),
        .start   (start),
        .rd_win  (rd_win),
        .rd_addr (rd_addr_q),
        .wr_addr (wr_addr_q)
    );

    rwa_hit #(.ADDR_W(ADDR_W)) u_hit (
        .clk        (clk),
        .rst        (rst),
        .rd_win     (rd_win),
        .wr_started (start.wr),
        .rd_started (start.rd),
        .addr       (addr),
        .wr_addr    (wr_addr_q),
        .rd_addr    (rd_addr_q),
        .fwd_pend   (fwd_pend)
    );

    rwa_merge #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .rd_started (start.rd),
        .fwd_pend   (fwd_pend),
        .arr_rdata  (arr_rdata),
        .wbuf_data  (wbuf_data),
        .wbuf_mask  (wbuf_mask),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_fwd     (rd_fwd)
    );

    assign rd_start = start.rd;
    assign wr_start = start.wr;
    assign rd_addr  = rd_addr_q;
    assign wr_addr  = wr_addr_q;

    // R1: a cycle after reset nothing is in flight
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!rd_start && !wr_start && !rd_valid && !rd_fwd));

endmodule

// File: tb/rw_start_arbiter_bench.sv
module rw_start_arbiter_bench;

    localparam int AW = 20;
    localparam int BW = 8;
    localparam int NB = 4;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_sel = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wbuf_data = '0;
    logic [NB-1:0] wbuf_mask = '0;
    logic [DW-1:0] arr_rdata = '0;
    logic          rd_start;
    logic [AW-1:0] rd_addr;
    logic          wr_start;
    logic [AW-1:0] wr_addr;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_fwd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model: 0 none, 1 read, 2 write
    int            m_last  = 0;
    logic [AW-1:0] m_waddr = '0;
    bit            m_hit   = 1'b0;

    always #5 clk = ~clk;

    rw_start_arbiter #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) u_rw_start_arbiter (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .wr_sel(wr_sel), .addr(addr),
        .wbuf_data(wbuf_data), .wbuf_mask(wbuf_mask), .arr_rdata(arr_rdata),
        .rd_start(rd_start), .rd_addr(rd_addr), .wr_start(wr_start), .wr_addr(wr_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_fwd(rd_fwd)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // R3 R4 R5 R7: expected start kind from requests and history
    function automatic int exp_op(input bit rs, input bit ws, input int last);
        if (rs && last != 1) return 1;
        if (ws && last != 2) return 2;
        return 0;
    endfunction

    // R9: byte i = bits [8i+7:8i], from write data where mask bit i is 1
    function automatic logic [DW-1:0] exp_merge(input logic [DW-1:0] arr, input logic [DW-1:0] wd,
                                                input logic [NB-1:0] wm);
        logic [DW-1:0] r;
        r = arr;
        for (int i = 0; i < NB; i++)
            if (wm[i]) r[i*BW +: BW] = wd[i*BW +: BW];
        return r;
    endfunction

    task automatic step(input bit rs, input bit ws, input logic [AW-1:0] a,
                        input logic [DW-1:0] arr, input logic [DW-1:0] wd,
                        input logic [NB-1:0] wm, input string tag);
        bit            e_valid;
        bit            e_fwd;
        bit            n_hit;
        int            nop;
        logic [DW-1:0] e_data;
        @(negedge clk);
        rd_sel = rs; wr_sel = ws; addr = a;
        arr_rdata = arr; wbuf_data = wd; wbuf_mask = wm;
        e_valid = (m_last == 1);
        e_fwd   = e_valid && m_hit;
        e_data  = m_hit ? exp_merge(arr, wd, wm) : arr;
        nop     = exp_op(rs, ws, m_last);
        n_hit   = (nop == 1) && (m_last == 2) && (a == m_waddr);
        @(posedge clk);
        #1;
        chk(rd_start == (nop == 1), {tag, " R3/R4/R5/R7 rd_start"}, 64'(rd_start), 64'(nop == 1));
        chk(wr_start == (nop == 2), {tag, " R3/R4/R5/R7 wr_start"}, 64'(wr_start), 64'(nop == 2));
        chk(!(rd_start && wr_start), {tag, " R2 one start"}, 64'({rd_start, wr_start}), 64'd0);
        if (nop == 1) chk(rd_addr == a, {tag, " R8 rd_addr"}, 64'(rd_addr), 64'(a));
        if (nop == 2) chk(wr_addr == a, {tag, " R8 wr_addr"}, 64'(wr_addr), 64'(a));
        chk(rd_valid == e_valid, {tag, " R11 rd_valid"}, 64'(rd_valid), 64'(e_valid));
        if (e_valid) begin
            chk(rd_data == e_data, {tag, (m_hit ? " R9 rd_data" : " R10 rd_data")},
                64'(rd_data), 64'(e_data));
            chk(rd_fwd == e_fwd, {tag, " R9/R10 rd_fwd"}, 64'(rd_fwd), 64'(e_fwd));
        end
        m_last = nop;
        if (nop == 2) m_waddr = a;
        m_hit = n_hit;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, '0, DW'($urandom), DW'($urandom), NB'($urandom), tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(!rd_start && !wr_start, "R1 starts in reset", 64'({rd_start, wr_start}), 64'd0);
        chk(!rd_valid && !rd_fwd, "R1 read output in reset", 64'({rd_valid, rd_fwd}), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R6: both held from idle alternates, starting with a read (R3, R4, R5)
        for (int i = 0; i < 6; i++)
            step(1'b1, 1'b1, AW'(i + 16), DW'($urandom), DW'($urandom), NB'($urandom), "R6 alt");
        idle("R6 tail");
        idle("R6 tail");

        // R7: second read is dropped and not retried
        step(1'b1, 1'b0, 20'h00100, 32'h11111111, 32'h0, 4'h0, "R7 rd1");
        step(1'b1, 1'b0, 20'h00101, 32'h22222222, 32'h0, 4'h0, "R7 rd2");
        idle("R7 after");
        chk(!rd_start && !wr_start, "R7 no retry", 64'({rd_start, wr_start}), 64'd0);
        step(1'b0, 1'b1, 20'h00200, 32'h0, 32'h0, 4'h0, "R7 wr1");
        step(1'b0, 1'b1, 20'h00201, 32'h0, 32'h0, 4'h0, "R7 wr2");
        idle("R7 after wr");

        // R9: write then read of same address, partial mask
        step(1'b0, 1'b1, 20'h00005, 32'h0, 32'h0, 4'h0, "R9 wr");
        step(1'b1, 1'b0, 20'h00005, 32'h0, 32'h0, 4'h0, "R9 rd");
        step(1'b0, 1'b0, 20'h0, 32'hAABBCCDD, 32'h11223344, 4'b0101, "R9 data");
        chk(rd_data == 32'hAA22CC44, "R9 directed merge", 64'(rd_data), 64'h00000000AA22CC44);
        idle("R9 tail");

        // R10: different address, then write separated by an idle edge
        step(1'b0, 1'b1, 20'h00006, 32'h0, 32'h0, 4'h0, "R10 wr");
        step(1'b1, 1'b0, 20'h00007, 32'h0, 32'h0, 4'h0, "R10 rd miss");
        step(1'b0, 1'b0, 20'h0, 32'h55667788, 32'hFFFFFFFF, 4'hF, "R10 data");
        chk(rd_data == 32'h55667788, "R10 directed miss", 64'(rd_data), 64'h0000000055667788);
        step(1'b0, 1'b1, 20'h00008, 32'h0, 32'h0, 4'h0, "R10 wr2");
        idle("R10 gap");
        step(1'b1, 1'b0, 20'h00008, 32'h0, 32'h0, 4'h0, "R10 rd late");
        step(1'b0, 1'b0, 20'h0, 32'h0BADF00D, 32'hFFFFFFFF, 4'hF, "R10 data2");
        chk(!rd_fwd, "R10 late write not forwarded", 64'(rd_fwd), 64'd0);

        // random mix, small address range to hit forwarding often
        for (int i = 0; i < 3000; i++)
            step(1'($urandom), 1'($urandom), AW'($urandom_range(0, 3)),
                 DW'($urandom), DW'($urandom), NB'($urandom), "rand");
        idle("end");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule